// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a signed multiply-accumulate engine built around a 64-bit accumulator kept as two 32-bit halves, a high word and a low word. Each start strobe takes two 32-bit operands and an operation select. The long operation multiplies the two full signed operands. The word operation multiplies only the sign-extended lower 16 bits of each operand. The signed product is added to the accumulator.

A saturation input decides what is written back. With saturation off, the full 64-bit sum is stored. With saturation on, the long operation clamps the high word. The word operation clamps the result to the signed 32-bit range and sets the high word to 1 as an overflow marker.

The multiply takes one pipeline stage and the accumulate takes a second stage. A done strobe marks the cycle in which the new accumulator value can first be read. Both halves can be read directly and written directly at any time. A clear input zeroes both halves.

Top module: `mac_sat_unit`

## Requirements
- R1: Long operation (op_word_i=0) with saturation off adds the signed 64-bit product of opa_i and opb_i, both taken as signed 32-bit values, to the accumulator {acc_hi_o, acc_lo_o}, wrapping modulo 2^64.
- R2: Word operation (op_word_i=1) sign-extends bits 15:0 of each operand and ignores bits 31:16, then adds the product to the 64-bit accumulator.
- R3: With sat_i=0, the word operation stores the full 64-bit sum without any clamping, even when the sum lies outside the signed 32-bit range.
- R4: Long operation with sat_i=1 and a negative 64-bit sum (bit 63 set): the low word is the sum's low word, and the high word is the sum's high word with bits 31:16 forced to 1.
- R5: Long operation with sat_i=1 and a non-negative sum: the low word is the sum's low word, and the high word keeps only bits 14:0 of the sum's high word, with bits 31:15 cleared.
- R6: Word operation with sat_i=1 and a sum below -2^31: the low word becomes 0x80000000 and the high word becomes 0x00000001.
- R7: Word operation with sat_i=1 and a sum above 2^31-1: the low word becomes 0x7FFFFFFF and the high word becomes 0x00000001. A sum inside the range is stored unchanged.
- R8: A start sampled at clock edge N updates the accumulator at edge N+1. done_o is high for exactly the one cycle after edge N+1.
- R9: clr_i zeroes both halves at the next edge. It takes priority over writes and over an accumulate in that cycle, and done_o stays low.
- R10: hi_we_i or lo_we_i loads the matching write data into that half, and the other half is kept. When either write falls in the same cycle as an accumulate commit, the accumulate is discarded and done_o stays low.
- R11: Starts on consecutive cycles are each accumulated onto the result of the previous operation.
- R12: After reset, both accumulator halves are zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one multiply-accumulate |
| op_word_i | input | 1 | 0 selects the long operation, 1 selects the word operation |
| sat_i | input | 1 | Saturation mode for this operation |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clr_i | input | 1 | Zeroes both accumulator halves |
| hi_we_i | input | 1 | Writes hi_wdata_i into the high word |
| hi_wdata_i | input | 32 | Data for the high word |
| lo_we_i | input | 1 | Writes lo_wdata_i into the low word |
| lo_wdata_i | input | 32 | Data for the low word |
| acc_hi_o | output | 32 | High accumulator word |
| acc_lo_o | output | 32 | Low accumulator word |
| done_o | output | 1 | One-cycle pulse when an accumulate result becomes visible |

## Verification
The commit of a pipelined accumulate can fall in the same cycle as a direct half write or a clear. The bench provokes this by issuing a start and then raising a write enable or clear on the very next cycle, which is the commit cycle. It then judges the outcome at the ports. The written half must hold the write data and the other half its old value, or both halves must read zero after a clear. In both cases done_o must stay low. Back-to-back starts also overlap a multiply with the previous commit, and each one is checked against the bench model.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int MAC_DW = 32;
    localparam int MAC_AW = 2 * MAC_DW;
    localparam int MAC_HW = MAC_DW / 2;
    localparam int MAC_NOPS = 2;

    typedef logic [MAC_DW-1:0] word_t;
    typedef logic [MAC_AW-1:0] wide_t;

    typedef struct packed {
        logic  valid;
        logic  word;
        logic  sat;
        wide_t prod;
    } prod_stage_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
        logic  done;
    } acc_state_t;
endpackage

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_word_i,
    input  logic        sat_i,
    input  word_t       opa_i,
    input  word_t       opb_i,
    output prod_stage_t stage_o
);
    word_t       ops_raw [MAC_NOPS];
    wide_t       ops_ext [MAC_NOPS];
    prod_stage_t stage_d, stage_q;

    assign ops_raw[0] = opa_i;
    assign ops_raw[1] = opb_i;

    // operand sign extension: narrow field or full word, widened to product width
    for (genvar g = 0; g < MAC_NOPS; g++) begin : g_ext
        word_t narrow;
        assign narrow = {{(MAC_DW-MAC_HW){ops_raw[g][MAC_HW-1]}}, ops_raw[g][MAC_HW-1:0]};
        always_comb begin
            if (op_word_i) begin
                ops_ext[g] = {{MAC_DW{narrow[MAC_DW-1]}}, narrow};
            end else begin
                ops_ext[g] = {{MAC_DW{ops_raw[g][MAC_DW-1]}}, ops_raw[g]};
            end
        end
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = start_i;
        if (start_i) begin
            stage_d.word = op_word_i;
            stage_d.sat  = sat_i;
            // low AW bits of the unsigned product of sign-extended values equal the signed product
            stage_d.prod = ops_ext[0] * ops_ext[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage_o = stage_q;

    assert_stage_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> stage_o.valid)
        else $error("R8: start not carried into multiply stage");
endmodule

// File: rtl/mac_sat_logic.sv
module mac_sat_logic
    import mac_pkg::*;
(
    input  wide_t acc_i,
    input  wide_t prod_i,
    input  logic  word_i,
    input  logic  sat_i,
    output wide_t result_o
);
    wide_t sum;
    word_t hi_sum, lo_sum, hi_long;
    logic  neg_ovf, pos_ovf;

    localparam word_t MARK_ONE = {{(MAC_DW-1){1'b0}}, 1'b1};
    localparam word_t LO_MIN   = {1'b1, {(MAC_DW-1){1'b0}}};
    localparam word_t LO_MAX   = {1'b0, {(MAC_DW-1){1'b1}}};

    always_comb begin
        sum    = acc_i + prod_i;
        hi_sum = sum[MAC_AW-1:MAC_DW];
        lo_sum = sum[MAC_DW-1:0];

        hi_long = hi_sum;
        if (sum[MAC_AW-1]) begin
            hi_long[MAC_DW-1:MAC_HW] = '1;
        end else begin
            hi_long[MAC_DW-1:MAC_HW-1] = '0;
        end

        // signed 32-bit range test: bits AW-1..DW-1 must all equal the sign
        neg_ovf = sum[MAC_AW-1] && !(&sum[MAC_AW-1:MAC_DW-1]);
        pos_ovf = !sum[MAC_AW-1] && (|sum[MAC_AW-1:MAC_DW-1]);

        if (!sat_i) begin
            result_o = sum;
        end else if (!word_i) begin
            result_o = {hi_long, lo_sum};
        end else if (neg_ovf) begin
            result_o = {MARK_ONE, LO_MIN};
        end else if (pos_ovf) begin
            result_o = {MARK_ONE, LO_MAX};
        end else begin
            result_o = sum;
        end
    end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  prod_stage_t stage_i,
    input  logic        clr_i,
    input  logic        hi_we_i,
    input  word_t       hi_wdata_i,
    input  logic        lo_we_i,
    input  word_t       lo_wdata_i,
    output word_t       hi_o,
    output word_t       lo_o,
    output logic        done_o
);
    acc_state_t acc_d, acc_q;
    wide_t      next_val;

    mac_sat_logic u_sat (
        .acc_i    ({acc_q.hi, acc_q.lo}),
        .prod_i   (stage_i.prod),
        .word_i   (stage_i.word),
        .sat_i    (stage_i.sat),
        .result_o (next_val)
    );

    always_comb begin
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        if (clr_i) begin
            acc_d.hi = '0;
            acc_d.lo = '0;
        end else if (hi_we_i || lo_we_i) begin
            if (hi_we_i) acc_d.hi = hi_wdata_i;
            if (lo_we_i) acc_d.lo = lo_wdata_i;
        end else if (stage_i.valid) begin
            acc_d.hi   = next_val[MAC_AW-1:MAC_DW];
            acc_d.lo   = next_val[MAC_DW-1:0];
            acc_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign hi_o   = acc_q.hi;
    assign lo_o   = acc_q.lo;
    assign done_o = acc_q.done;

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (hi_o == '0 && lo_o == '0 && !done_o))
        else $error("R9: clear did not zero accumulator");

    assert_write_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we_i && !clr_i) |=> (hi_o == $past(hi_wdata_i) && !done_o))
        else $error("R10: high write lost");

    assert_write_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we_i && !clr_i) |=> (lo_o == $past(lo_wdata_i) && !done_o))
        else $error("R10: low write lost");

    assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(stage_i.valid))
        else $error("R8: done without a pending operation");

    assert_long_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_i.valid && stage_i.sat && !stage_i.word && !clr_i && !hi_we_i && !lo_we_i)
        |=> (hi_o[MAC_DW-1:MAC_HW] == '1 || hi_o[MAC_DW-1:MAC_HW-1] == '0))
        else $error("R4/R5: long clamp violated");

    assert_word_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_i.valid && stage_i.sat && stage_i.word && !clr_i && !hi_we_i && !lo_we_i)
        |=> (hi_o == {{(MAC_DW-1){1'b0}}, 1'b1} || hi_o == {MAC_DW{lo_o[MAC_DW-1]}}))
        else $error("R6/R7: word clamp violated");
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_word_i,
    input  logic        sat_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic        clr_i,
    input  logic        hi_we_i,
    input  logic [31:0] hi_wdata_i,
    input  logic        lo_we_i,
    input  logic [31:0] lo_wdata_i,
    output logic [31:0] acc_hi_o,
    output logic [31:0] acc_lo_o,
    output logic        done_o
);
    prod_stage_t stage;

    mac_mult_stage u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_word_i (op_word_i),
        .sat_i     (sat_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .stage_o   (stage)
    );

    mac_acc_reg u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_i    (stage),
        .clr_i      (clr_i),
        .hi_we_i    (hi_we_i),
        .hi_wdata_i (hi_wdata_i),
        .lo_we_i    (lo_we_i),
        .lo_wdata_i (lo_wdata_i),
        .hi_o       (acc_hi_o),
        .lo_o       (acc_lo_o),
        .done_o     (done_o)
    );
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, op_word_i = 1'b0, sat_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic        clr_i = 1'b0, hi_we_i = 1'b0, lo_we_i = 1'b0;
    logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [63:0] model_acc = '0;

    always #2.5 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_word_i(op_word_i),
        .sat_i(sat_i), .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i),
        .hi_we_i(hi_we_i), .hi_wdata_i(hi_wdata_i), .lo_we_i(lo_we_i),
        .lo_wdata_i(lo_wdata_i), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o),
        .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] mac_model(logic [63:0] acc, logic [31:0] a,
                                              logic [31:0] b, logic word, logic sat);
        longint pa, pb, s;
        logic [31:0] hi;
        pa = word ? longint'($signed(a[15:0])) : longint'($signed(a));
        pb = word ? longint'($signed(b[15:0])) : longint'($signed(b));
        s  = longint'(acc) + pa * pb;
        if (!sat) return 64'(s);
        if (!word) begin
            hi = 32'(s >>> 32);
            hi = (s < 0) ? (hi | 32'hFFFF_0000) : (hi & 32'h0000_7FFF);
            return {hi, 32'(s)};
        end
        if (s < -64'sd2147483648) return {32'd1, 32'h8000_0000};
        if (s > 64'sd2147483647)  return {32'd1, 32'h7FFF_FFFF};
        return 64'(s);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_acc(logic [31:0] hi, logic [31:0] lo);
        @(negedge clk);
        hi_we_i = 1'b1; lo_we_i = 1'b1; hi_wdata_i = hi; lo_wdata_i = lo;
        @(negedge clk);
        hi_we_i = 1'b0; lo_we_i = 1'b0;
        model_acc = {hi, lo};
    endtask

    // drive one op, check done and result in the commit-visible cycle, then done falls
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic word,
                          logic sat, logic [63:0] lit, logic use_lit);
        logic [63:0] exp;
        @(negedge clk);
        start_i = 1'b1; opa_i = a; opb_i = b; op_word_i = word; sat_i = sat;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        exp = use_lit ? lit : mac_model(model_acc, a, b, word, sat);
        model_acc = exp;
        check(req, {acc_hi_o, acc_lo_o}, exp);
        check({req, " done"}, {63'd0, done_o}, 64'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #12;
        check("R12 reset", {acc_hi_o, acc_lo_o}, 64'd0);
        check("R12 reset done", {63'd0, done_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R12 after release", {acc_hi_o, acc_lo_o, 31'd0, done_o}, 96'd0);

        // R1 long, no saturation
        write_acc(32'h0, 32'h0);
        run_op("R1 long -3*5", 32'hFFFF_FFFD, 32'd5, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF1, 1'b1);
        run_op("R1 long big", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 64'h0, 1'b0);
        // R8 done lasts one cycle
        @(negedge clk);
        check("R8 done falls", {63'd0, done_o}, 64'd0);

        // R2 word ignores upper bits
        write_acc(32'h0, 32'd10);
        run_op("R2 word -2*3", 32'h1234_FFFE, 32'hABCD_0003, 1'b1, 1'b0, 64'd4, 1'b1);

        // R3 word without saturation does not clamp
        write_acc(32'h0, 32'h7FFF_FFFF);
        run_op("R3 word wrap", 32'd1, 32'd1, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 1'b1);

        // R4 long saturation, negative sum
        write_acc(32'h8000_0000, 32'h0);
        run_op("R4 long neg", 32'd1, 32'd1, 1'b0, 1'b1, 64'hFFFF_0000_0000_0001, 1'b1);
        // R5 long saturation, non-negative sum
        write_acc(32'h1234_5678, 32'd5);
        run_op("R5 long pos", 32'd0, 32'd0, 1'b0, 1'b1, 64'h0000_5678_0000_0005, 1'b1);

        // R6 word saturation low
        write_acc(32'hFFFF_FFFF, 32'h8000_0000);
        run_op("R6 word min", 32'h0000_FFFF, 32'd1, 1'b1, 1'b1, 64'h0000_0001_8000_0000, 1'b1);
        // R7 word saturation high and in range
        write_acc(32'h0, 32'h7FFF_FFFF);
        run_op("R7 word max", 32'd1, 32'd1, 1'b1, 1'b1, 64'h0000_0001_7FFF_FFFF, 1'b1);
        write_acc(32'h0, 32'h0);
        run_op("R7 word in range", 32'h0000_8000, 32'h0000_8000, 1'b1, 1'b1, 64'h0000_0000_4000_0000, 1'b1);

        // R11 back-to-back starts
        write_acc(32'h0, 32'd100);
        @(negedge clk);
        start_i = 1'b1; op_word_i = 1'b0; sat_i = 1'b0; opa_i = 32'd3; opb_i = 32'd4;
        @(negedge clk);
        opa_i = 32'hFFFF_FFFE; opb_i = 32'd50;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 first", {acc_hi_o, acc_lo_o}, 64'd112);
        @(negedge clk);
        check("R11 second", {acc_hi_o, acc_lo_o}, 64'd12);
        check("R11 done", {63'd0, done_o}, 64'd1);
        model_acc = 64'd12;

        // R10 write collides with commit
        @(negedge clk);
        start_i = 1'b1; opa_i = 32'd7; opb_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0; hi_we_i = 1'b1; hi_wdata_i = 32'hCAFE_0001;
        @(negedge clk);
        hi_we_i = 1'b0;
        check("R10 write wins", {acc_hi_o, acc_lo_o}, {32'hCAFE_0001, 32'd12});
        check("R10 no done", {63'd0, done_o}, 64'd0);
        model_acc = {32'hCAFE_0001, 32'd12};

        // R9 clear collides with commit and a write
        @(negedge clk);
        start_i = 1'b1; opa_i = 32'd9; opb_i = 32'd9;
        @(negedge clk);
        start_i = 1'b0; clr_i = 1'b1; lo_we_i = 1'b1; lo_wdata_i = 32'h5555_5555;
        @(negedge clk);
        clr_i = 1'b0; lo_we_i = 1'b0;
        check("R9 clear wins", {acc_hi_o, acc_lo_o}, 64'd0);
        check("R9 no done", {63'd0, done_o}, 64'd0);
        model_acc = 64'd0;

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            logic w, s;
            int sel;
            sel = int'($urandom_range(0, 5));
            a = $urandom(); b = $urandom();
            if (sel == 0) begin a = 32'h0000_7FFF; b = 32'h0000_8000; end
            if (sel == 1) begin a = 32'h8000_0000; b = 32'h8000_0000; end
            w = $urandom_range(0, 1) == 1;
            s = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 7) == 0) write_acc($urandom(), $urandom());
            run_op(w ? (s ? "R7 rand word sat" : "R2 rand word")
                     : (s ? "R4 rand long sat" : "R1 rand long"),
                   a, b, w, s, 64'h0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule